// File: doc/BRIEF.md
# Nibble Flux-Pulse Writer

This block turns a stream of 4-bit values into timed strobes on the active-low write-data line of a disk drive. The drive records a flux transition only on a falling edge of that line, so every value is written as two falling edges. The first edge opens a symbol. The second edge falls at an offset that encodes the value. The block replaces bit-cell encoding with a position code: sixteen possible edge positions, one clock step apart, inside a one-microsecond window.

The block runs from a 16 MHz clock. A symbol lasts 80 clocks. The value for each symbol is taken through a valid/ready handshake in the symbol's first cycle. An enable input starts and stops the writer. An optional alignment mode holds the first symbol until the index input rises. When the producer has no data ready at a symbol boundary, the block writes a fixed filler value and flags an underrun. The block enforces a minimum spacing of 32 clocks (2 µs) between any two falling edges, including when the writer is restarted.

Top module: `nibble_flux_writer`

## Requirements
- R1: While reset is held, and in the first cycle after it, `wdata_n_o` is 1, `nib_ready_o` is 0 and `underrun_o` is 0.
- R2: While `wr_en_i` is 0, `nib_ready_o` stays 0 and no value is taken. From the cycle after `wr_en_i` is seen at 0, `wdata_n_o` is 1.
- R3: A symbol's start edge (a 1-to-0 change of `wdata_n_o`) comes on the clock edge that ends the cycle in which `nib_ready_o` is 1. While the writer stays enabled, start edges repeat every 80 clocks.
- R4: The data edge falls exactly 32 + v clocks after its start edge. Here v is the unsigned 4-bit value taken for that symbol, so the data edge falls 32 to 47 clocks after the start edge.
- R5: Each low pulse lasts 8 clocks unless the writer is disabled during the pulse.
- R6: `nib_ready_o` is 1 for exactly one cycle per symbol, in the symbol's first cycle. A value is taken when `nib_valid_i` and `nib_ready_o` are both 1.
- R7: If `nib_valid_i` is 0 in a symbol's first cycle, `underrun_o` is 1 in that cycle, and the symbol carries the filler value 0 (its data edge falls 32 clocks after its start edge).
- R8: With `align_idx_i` at 1, an idle writer does not start until `index_i` goes from 0 to 1. `nib_ready_o` first rises three clock edges after `index_i` is first sampled at 1: two synchroniser stages, then the start register.
- R9: After the writer is disabled and re-enabled, the first new start edge falls at least 32 clocks after the last falling edge written before the stop.
- R10: Any two successive falling edges of `wdata_n_o` are at least 32 clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write enable; 0 stops the writer and holds the line high |
| align_idx_i | input | 1 | 1 makes an idle writer wait for a rising index edge before starting |
| index_i | input | 1 | Once-per-revolution index pulse from the drive |
| nib_valid_i | input | 1 | Producer has a value ready |
| nib_data_i | input | 4 | Value to write |
| nib_ready_o | output | 1 | Value is taken this cycle if valid |
| underrun_o | output | 1 | No value was ready at the symbol boundary; filler is written |
| wdata_n_o | output | 1 | Active-low write-data strobe to the drive |

## Verification
The bench decodes every symbol from the gap between its two falling edges and compares the result with the value the handshake took. A design with an off-by-one in the data offset, or with the value latched one symbol late, would decode wrong at the extremes 0 and 15. Starving the producer checks that the filler value and the underrun flag come out together. A writer that held the last value, or that stalled, would show a wrong gap or a missing pulse. Dropping the enable just after a data edge and raising it again at once tests the restart hold-off: a writer that restarted at once would put two transitions a few clocks apart. The index test checks that nothing starts before the index rises and that the start lands on the exact cycle after the synchroniser.

// File: rtl/nfw_pkg.sv
package nfw_pkg;

   // Offset of the data edge from the start edge, in clocks
   function automatic int data_edge_pos(input int base_clks, input int step_clks, input int value);
      return base_clks + value * step_clks;
   endfunction

   // Latest data edge for a given value width
   function automatic int last_data_pos(input int base_clks, input int step_clks, input int nib_w);
      return base_clks + ((1 << nib_w) - 1) * step_clks;
   endfunction

endpackage

// File: rtl/nfw_index_sync.sv
module nfw_index_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic index_i,
   output logic rise_o
);
   generate
      if (STAGES == 0) begin : g_direct
         logic prev_q;
         always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= index_i;
         end
         assign rise_o = index_i & ~prev_q;
      end else begin : g_chain
         logic [STAGES:0] sh_q;
         always_ff @(posedge clk) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[STAGES-1:0], index_i};
         end
         assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
      end
   endgenerate
endmodule

// File: rtl/nfw_symbol_timer.sv
module nfw_symbol_timer #(
   parameter int SYM_CLKS = 80,
   localparam int CW = $clog2(SYM_CLKS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en_i,
   input  logic          start_ok_i,
   output logic          run_o,
   output logic [CW-1:0] cnt_o,
   output logic          sym_start_o
);
   localparam logic [CW-1:0] LAST = CW'(SYM_CLKS - 1);

   logic          run_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (!wr_en_i) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (run_q) begin
         cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end else if (start_ok_i) begin
         run_q <= 1'b1;
         cnt_q <= '0;
      end
   end

   assign run_o       = run_q;
   assign cnt_o       = cnt_q;
   assign sym_start_o = wr_en_i & run_q & (cnt_q == '0);

   // R3: the phase counter never leaves the symbol
   a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (cnt_q <= LAST));

   // R6: a symbol boundary never lasts two cycles
   a_r6_single_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      sym_start_o |=> !sym_start_o);
endmodule

// File: rtl/nfw_nibble_latch.sv
module nfw_nibble_latch #(
   parameter int NIB_W = 4,
   parameter logic [NIB_W-1:0] FILL_NIB = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sym_start_i,
   input  logic             nib_valid_i,
   input  logic [NIB_W-1:0] nib_data_i,
   output logic             nib_ready_o,
   output logic             underrun_o,
   output logic [NIB_W-1:0] val_o
);
   logic [NIB_W-1:0] val_q;

   always_ff @(posedge clk) begin
      if (!rst_n)           val_q <= FILL_NIB;
      else if (sym_start_i) val_q <= nib_valid_i ? nib_data_i : FILL_NIB;
   end

   assign nib_ready_o = sym_start_i;
   assign underrun_o  = sym_start_i & ~nib_valid_i;
   assign val_o       = val_q;

   // R7: a starved boundary leaves the filler value in the symbol
   a_r7_filler_taken: assert property (@(posedge clk) disable iff (!rst_n)
      underrun_o |=> (val_q == FILL_NIB));

   // R6: a taken value is the one the symbol carries
   a_r6_value_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (nib_ready_o && nib_valid_i) |=> (val_q == $past(nib_data_i)));
endmodule

// File: rtl/nfw_pulse_shaper.sv
module nfw_pulse_shaper #(
   parameter int NIB_W        = 4,
   parameter int SYM_CLKS     = 80,
   parameter int BASE_CLKS    = 32,
   parameter int CLK_PER_STEP = 1,
   parameter int PULSE_CLKS   = 8,
   localparam int CW = $clog2(SYM_CLKS),
   localparam int GW = $clog2(SYM_CLKS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_i,
   input  logic             run_i,
   input  logic [CW-1:0]    cnt_i,
   input  logic [NIB_W-1:0] val_i,
   output logic             wdata_n_o,
   output logic             gap_ok_o
);
   import nfw_pkg::*;

   localparam logic [GW-1:0] GAP_MAX = GW'(SYM_CLKS);

   logic          wdata_n_q;
   logic [GW-1:0] gap_q;
   int            dpos;
   int            phase;
   logic          in_window;
   logic          low_nxt;

   always_comb begin
      dpos      = data_edge_pos(BASE_CLKS, CLK_PER_STEP, int'(val_i));
      phase     = int'(cnt_i);
      in_window = (phase < PULSE_CLKS) ||
                  ((phase >= dpos) && (phase < dpos + PULSE_CLKS));
      low_nxt   = wr_en_i & run_i & in_window;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wdata_n_q <= 1'b1;
         gap_q     <= GAP_MAX;
      end else begin
         wdata_n_q <= ~low_nxt;
         if (low_nxt && wdata_n_q)  gap_q <= '0;
         else if (gap_q != GAP_MAX) gap_q <= gap_q + 1'b1;
      end
   end

   assign wdata_n_o = wdata_n_q;
   assign gap_ok_o  = (int'(gap_q) >= BASE_CLKS);

   // R10: successive transitions keep the minimum spacing
   a_r10_min_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wdata_n_q) |-> (int'($past(gap_q)) + 1 >= BASE_CLKS));

   // R5: a pulse is never a single cycle while enabled
   a_r5_pulse_held: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(wdata_n_q) && wr_en_i) |=> !wdata_n_q);

   // R2: disabled writer releases the line
   a_r2_line_released: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en_i) |-> wdata_n_q);
endmodule

// File: rtl/nibble_flux_writer.sv
module nibble_flux_writer #(
   parameter int NIB_W        = 4,
   parameter int SYM_CLKS     = 80,
   parameter int BASE_CLKS    = 32,
   parameter int CLK_PER_STEP = 1,
   parameter int PULSE_CLKS   = 8,
   parameter int SYNC_STAGES  = 2,
   parameter logic [NIB_W-1:0] FILL_NIB = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_i,
   input  logic             align_idx_i,
   input  logic             index_i,
   input  logic             nib_valid_i,
   input  logic [NIB_W-1:0] nib_data_i,
   output logic             nib_ready_o,
   output logic             underrun_o,
   output logic             wdata_n_o
);
   import nfw_pkg::*;

   localparam int CW       = $clog2(SYM_CLKS);
   localparam int LAST_POS = last_data_pos(BASE_CLKS, CLK_PER_STEP, NIB_W);

   generate
      if (LAST_POS + BASE_CLKS > SYM_CLKS) begin : g_bad_period
         $error("symbol period too short for spacing after latest data edge");
      end
      if (PULSE_CLKS < 1 || PULSE_CLKS >= BASE_CLKS) begin : g_bad_pulse
         $error("pulse width must be between 1 and the minimum spacing");
      end
      if (CLK_PER_STEP < 1) begin : g_bad_step
         $error("edge step must be at least one clock");
      end
   endgenerate

   logic          idx_rise;
   logic          run;
   logic [CW-1:0] cnt;
   logic          sym_start;
   logic [NIB_W-1:0] val;
   logic          gap_ok;
   logic          start_ok;

   assign start_ok = gap_ok & (~align_idx_i | idx_rise);

   nfw_index_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .index_i (index_i),
      .rise_o  (idx_rise)
   );

   nfw_symbol_timer #(.SYM_CLKS(SYM_CLKS)) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en_i     (wr_en_i),
      .start_ok_i  (start_ok),
      .run_o       (run),
      .cnt_o       (cnt),
      .sym_start_o (sym_start)
   );

   nfw_nibble_latch #(.NIB_W(NIB_W), .FILL_NIB(FILL_NIB)) u_latch (
      .clk         (clk),
      .rst_n       (rst_n),
      .sym_start_i (sym_start),
      .nib_valid_i (nib_valid_i),
      .nib_data_i  (nib_data_i),
      .nib_ready_o (nib_ready_o),
      .underrun_o  (underrun_o),
      .val_o       (val)
   );

   nfw_pulse_shaper #(
      .NIB_W(NIB_W), .SYM_CLKS(SYM_CLKS), .BASE_CLKS(BASE_CLKS),
      .CLK_PER_STEP(CLK_PER_STEP), .PULSE_CLKS(PULSE_CLKS)
   ) u_shaper (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en_i),
      .run_i     (run),
      .cnt_i     (cnt),
      .val_i     (val),
      .wdata_n_o (wdata_n_o),
      .gap_ok_o  (gap_ok)
   );

   // R2: nothing is taken while disabled
   a_r2_no_accept_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i |-> !nib_ready_o);

   // R3: a taken boundary is followed by a falling edge
   a_r3_start_follows: assert property (@(posedge clk) disable iff (!rst_n)
      nib_ready_o |=> !wdata_n_o);

   // R1: idle outputs are quiet
   a_r1_quiet_outputs: assert property (@(posedge clk)
      !rst_n |=> (wdata_n_o && !nib_ready_o && !underrun_o) || rst_n);
endmodule

// File: tb/sim_nibble_flux_writer.sv
`timescale 1ns/100ps
module sim_nibble_flux_writer;
   localparam real CLK_PERIOD = 62.5;
   localparam int  SYM  = 80;
   localparam int  BASE = 32;
   localparam int  PW   = 8;
   localparam int  FILL = 0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic align = 1'b0;
   logic index = 1'b0;
   logic valid = 1'b0;
   logic [3:0] data = '0;
   logic ready, under, wdn;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nibble_flux_writer u0 (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .align_idx_i(align),
      .index_i(index), .nib_valid_i(valid), .nib_data_i(data),
      .nib_ready_o(ready), .underrun_o(under), .wdata_n_o(wdn)
   );

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   // ---------- behavioural reference ----------
   int m_run = 0, m_pos = 0, m_val = FILL, m_wrn = 1, m_gap = SYM;
   int h0 = 0, h1 = 0, h2 = 0;
   int acc[$];
   int src[$];
   bit hs = 0;

   always @(posedge clk) begin
      cyc++;
      hs = 0;
      if (!rst_n) begin
         m_run = 0; m_pos = 0; m_val = FILL; m_wrn = 1; m_gap = SYM;
         h0 = 0; h1 = 0; h2 = 0;
      end else begin
         int rdy, rise, low, ok_gap;
         rdy    = (wr_en && m_run && m_pos == 0) ? 1 : 0;
         rise   = (h1 == 1 && h2 == 0) ? 1 : 0;
         ok_gap = (m_gap >= BASE) ? 1 : 0;
         low    = (wr_en && m_run && ((m_pos < PW) ||
                  (m_pos >= BASE + m_val && m_pos < BASE + m_val + PW))) ? 1 : 0;
         if (low && m_wrn) m_gap = 0; else if (m_gap < SYM) m_gap++;
         m_wrn = low ? 0 : 1;
         if (rdy) begin
            m_val = valid ? int'(data) : FILL;
            acc.push_back(m_val);
            hs = valid;
         end
         if (!wr_en) begin m_run = 0; m_pos = 0; end
         else if (m_run) m_pos = (m_pos + 1) % SYM;
         else if (ok_gap && (!align || rise)) begin m_run = 1; m_pos = 0; end
         h2 = h1; h1 = h0; h0 = int'(index);
      end
   end

   // ---------- per-cycle compare and edge decoder ----------
   int prev_wn = 1, low_len = 0, trunc = 0;
   int phase = 0, have_start = 0, t_start = 0, last_fall = -1000;
   int data_evt = 0, ready_cnt = 0, under_cnt = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         int e_rdy;
         e_rdy = (wr_en && m_run && m_pos == 0) ? 1 : 0;
         chk(int'(wdn) == m_wrn, wr_en ? "R3" : "R2", "write line", int'(wdn), m_wrn);
         chk(int'(ready) == e_rdy, "R6", "ready", int'(ready), e_rdy);
         chk(int'(under) == (e_rdy && !valid), "R7", "underrun", int'(under), int'(e_rdy && !valid));
         if (ready) ready_cnt++;
         if (under) under_cnt++;
         if (!wr_en) begin
            acc.delete(); phase = 0; have_start = 0;
            if (!wdn) trunc = 1;
         end
         if (prev_wn == 1 && wdn == 0) begin
            chk(cyc - last_fall >= BASE, "R10", "edge spacing", cyc - last_fall, BASE);
            if (phase == 0) begin
               if (have_start) chk(cyc - t_start == SYM, "R3", "symbol period", cyc - t_start, SYM);
               t_start = cyc; have_start = 1; phase = 1;
            end else begin
               int ev;
               ev = (acc.size() > 0) ? acc.pop_front() : -1;
               chk(cyc - t_start == BASE + ev, "R4", "data edge offset", cyc - t_start, BASE + ev);
               phase = 0; data_evt++;
            end
            last_fall = cyc; low_len = 0; trunc = 0;
         end
         if (!wdn) low_len++;
         if (prev_wn == 0 && wdn == 1) begin
            if (!trunc) chk(low_len == PW, "R5", "pulse width", low_len, PW);
         end
         prev_wn = int'(wdn);
      end
   end

   // ---------- stimulus ----------
   bit feeding = 0;
   task automatic tick();
      @(posedge clk); #1;
      if (hs && src.size() > 0) void'(src.pop_front());
      valid = feeding && src.size() > 0;
      data  = (src.size() > 0) ? 4'(src[0]) : 4'h0;
   endtask

   always @(posedge clk) begin
      if (cyc > 200000) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: got %0d expected %0d", cyc, 200000);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int vals[20] = '{0,15,7,1,8,14,2,13,3,12,4,11,5,10,6,9,15,0,15,0};
      int bad, base_u, t_drop, n;
      repeat (5) tick();
      chk(wdn == 1'b1, "R1", "reset line", int'(wdn), 1);
      chk(ready == 1'b0, "R1", "reset ready", int'(ready), 0);
      chk(under == 1'b0, "R1", "reset underrun", int'(under), 0);
      rst_n = 1'b1;
      tick();
      chk(wdn == 1'b1 && !ready && !under, "R1", "first cycle after reset", int'(wdn), 1);

      // disabled with data offered
      foreach (vals[i]) src.push_back(vals[i]);
      feeding = 1;
      bad = 0;
      for (int i = 0; i < 20; i++) begin tick(); if (ready || !wdn) bad++; end
      chk(bad == 0, "R2", "activity while disabled", bad, 0);
      chk(src.size() == 20, "R2", "values left untaken", src.size(), 20);

      // stream, then starve
      wr_en = 1'b1;
      n = 0;
      while (src.size() > 0 && n < 5000) begin tick(); n++; end
      chk(src.size() == 0, "R6", "stream drained", src.size(), 0);
      base_u = under_cnt;
      repeat (4 * SYM) tick();
      chk(under_cnt - base_u >= 3, "R7", "underrun flags while starved", under_cnt - base_u, 3);

      // drop just after a data edge, re-enable at once
      src.push_back(15); src.push_back(6); src.push_back(0);
      n = data_evt;
      while (data_evt == n) tick();
      tick(); tick();
      t_drop = last_fall;
      wr_en = 1'b0; tick(); wr_en = 1'b1;
      while (last_fall == t_drop) tick();
      chk(last_fall - t_drop >= BASE, "R9", "restart spacing", last_fall - t_drop, BASE);
      repeat (3 * SYM) tick();

      // index alignment
      wr_en = 1'b0; repeat (60) tick();
      src.push_back(9); src.push_back(3);
      align = 1'b1; wr_en = 1'b1;
      n = ready_cnt;
      repeat (300) tick();
      chk(ready_cnt == n, "R8", "ready before index", ready_cnt - n, 0);
      index = 1'b1;
      n = 0;
      while (!ready && n < 20) begin tick(); n++; end
      chk(n == 3, "R8", "edges from index to ready", n, 3);
      repeat (10) tick();
      index = 1'b0;
      repeat (4 * SYM) tick();
      wr_en = 1'b0; repeat (5) tick();

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule